// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block picks one interrupt to service out of a parameterised set of sources (43 by default). It also says whether that interrupt should interrupt the handler that is currently running. Each source carries a programmable 4-bit priority, and a lower number means a more urgent source. Only sources whose pending bit and enable bit are both set take part.

A 3-bit grouping code sets a binary point inside every priority value. The bits above the point form the group part, which alone decides preemption. The bits below the point form the sub part, which only orders sources that share a group.

The winner is chosen on the full priority value first, and the lowest source number breaks any remaining tie. The preempt request compares the winner's group part with the group part of the active handler's priority. When no handler is running, any valid winner is offered for preemption. All outputs are registered, so they reflect the inputs seen at the previous clock edge.

Top module: `grp_irq_arb`

## Requirements
- R1: A source competes only when its `pend` bit and its `en` bit are both 1. When no source competes, `win_valid` and `preempt` are 0 one cycle later.
- R2: Among competing sources, the one with the numerically smallest 4-bit priority (`prio_flat[4*i+3:4*i]` for source i) is reported on `win_id`.
- R3: When several competing sources share the smallest priority value, the lowest source number wins.
- R4: A grouping code g from 3 to 7 gives g-3 sub bits, taken from the least significant end of the priority. This yields group.sub splits of 4.0, 3.1, 2.2, 1.3 and 0.4, and the group part is the priority with its sub bits cleared.
- R5: Grouping codes 0, 1 and 2 give the same result as code 3, so all four bits are group bits.
- R6: When `act_valid` is 1, `preempt` is 1 only if the winner's group part is strictly smaller than the group part of `act_prio`. Sub bits are ignored in this comparison, and equal groups never preempt.
- R7: When `act_valid` is 0, `preempt` equals `win_valid`.
- R8: With grouping code 7 and `act_valid` at 1, `preempt` stays 0 for every winner.
- R9: `win_id`, `win_valid` and `preempt` are registered with one cycle of latency. While `rst_n` is 0 they are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend | input | NUM_SRC | Pending bit per source |
| en | input | NUM_SRC | Enable bit per source |
| prio_flat | input | NUM_SRC*PRIO_W | Priority per source; source i at bits [PRIO_W*i +: PRIO_W] |
| grouping | input | 3 | Binary point code |
| act_valid | input | 1 | A handler is currently running |
| act_prio | input | PRIO_W | Priority of the running handler |
| win_id | output | ID_W | Number of the winning source |
| win_valid | output | 1 | At least one source competed |
| preempt | output | 1 | Winner may preempt the running handler |

## Verification
A table of two-source patterns covers several cases. Priority order runs against source order, so the priority comparison can be told apart from plain index order. Equal priorities isolate the index tiebreak. The same pair of priorities is run under different grouping codes and active priorities, which shows whether sub bits leak into the preemption compare and whether the strict-less rule holds at equality.

Directed cases cover the following:
- every source pending at one level;
- pending but disabled sources;
- the 0.4 split;
- the idle handler;
- one-cycle latency, by changing the inputs for a single cycle.

// File: rtl/grp_irq_pkg.sv
`timescale 1ns/1ps
package grp_irq_pkg;
  localparam int MAX_PW = 8;
  localparam int FULL_GROUP_CODE = 3;

  // number of sub-priority bits selected by a grouping code
  function automatic int sub_bits(input logic [2:0] g);
    return (int'(g) < FULL_GROUP_CODE) ? 0 : int'(g) - FULL_GROUP_CODE;
  endfunction

  // mask that keeps the group part of a priority value
  function automatic logic [MAX_PW-1:0] group_mask(input logic [2:0] g);
    logic [MAX_PW-1:0] m;
    m = '1;
    return m << sub_bits(g);
  endfunction
endpackage

// File: rtl/prio_min_tree.sv
`timescale 1ns/1ps
module prio_min_tree #(
  parameter int N  = 43,
  parameter int PW = 4,
  parameter int IW = 6
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio_flat,
  output logic            o_valid,
  output logic [PW-1:0]   o_prio,
  output logic [IW-1:0]   o_id
);
  localparam int LVL   = (N > 1) ? $clog2(N) : 1;
  localparam int LEAF  = 1 << LVL;
  localparam int NODES = 2 * LEAF - 1;

  logic          nv [NODES];
  logic [PW-1:0] np [NODES];
  logic [IW-1:0] ni [NODES];

  // leaves: lower source numbers sit further left
  for (genvar j = 0; j < LEAF; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nv[LEAF-1+j] = req[j];
      assign np[LEAF-1+j] = prio_flat[j*PW +: PW];
      assign ni[LEAF-1+j] = IW'(j);
    end else begin : g_pad
      assign nv[LEAF-1+j] = 1'b0;
      assign np[LEAF-1+j] = '1;
      assign ni[LEAF-1+j] = '0;
    end
  end

  // internal nodes: left child wins ties, which keeps the lower index
  for (genvar k = 0; k < LEAF - 1; k++) begin : g_node
    logic take_l;
    assign take_l = nv[2*k+1] && (!nv[2*k+2] || (np[2*k+1] <= np[2*k+2]));
    assign nv[k]  = nv[2*k+1] | nv[2*k+2];
    assign np[k]  = take_l ? np[2*k+1] : np[2*k+2];
    assign ni[k]  = take_l ? ni[2*k+1] : ni[2*k+2];
  end

  assign o_valid = nv[0];
  assign o_prio  = np[0];
  assign o_id    = ni[0];
endmodule

// File: rtl/grp_preempt_judge.sv
`timescale 1ns/1ps
module grp_preempt_judge #(
  parameter int PW = 4
) (
  input  logic          cand_valid,
  input  logic [PW-1:0] cand_prio,
  input  logic [2:0]    grouping,
  input  logic          act_valid,
  input  logic [PW-1:0] act_prio,
  output logic          preempt
);
  import grp_irq_pkg::*;

  logic [MAX_PW-1:0] full_mask;
  logic [PW-1:0]     mask;
  logic [PW-1:0]     cand_grp;
  logic [PW-1:0]     act_grp;

  assign full_mask = group_mask(grouping);
  assign mask      = full_mask[PW-1:0];
  assign cand_grp  = cand_prio & mask;
  assign act_grp   = act_prio & mask;
  assign preempt   = cand_valid && (!act_valid || (cand_grp < act_grp));
endmodule

// File: rtl/grp_irq_arb.sv
`timescale 1ns/1ps
module grp_irq_arb #(
  parameter int NUM_SRC = 43,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC-1:0]       en,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [2:0]               grouping,
  input  logic                     act_valid,
  input  logic [PRIO_W-1:0]        act_prio,
  output logic [ID_W-1:0]          win_id,
  output logic                     win_valid,
  output logic                     preempt
);
  logic [NUM_SRC-1:0] req_vec;
  logic               nxt_valid;
  logic [PRIO_W-1:0]  nxt_prio;
  logic [ID_W-1:0]    nxt_id;
  logic               nxt_preempt;

  assign req_vec = pend & en;

  prio_min_tree #(.N(NUM_SRC), .PW(PRIO_W), .IW(ID_W)) u_tree (
    .req      (req_vec),
    .prio_flat(prio_flat),
    .o_valid  (nxt_valid),
    .o_prio   (nxt_prio),
    .o_id     (nxt_id)
  );

  grp_preempt_judge #(.PW(PRIO_W)) u_judge (
    .cand_valid(nxt_valid),
    .cand_prio (nxt_prio),
    .grouping  (grouping),
    .act_valid (act_valid),
    .act_prio  (act_prio),
    .preempt   (nxt_preempt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_id    <= '0;
      win_valid <= 1'b0;
      preempt   <= 1'b0;
    end else begin
      win_id    <= nxt_valid ? nxt_id : '0;
      win_valid <= nxt_valid;
      preempt   <= nxt_preempt;
    end
  end
endmodule

// File: rtl/grp_irq_arb_chk.sv
`timescale 1ns/1ps
module grp_irq_arb_chk #(
  parameter int N  = 43,
  parameter int IW = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_vec,
  input logic [2:0]   grouping,
  input logic         act_valid,
  input logic [IW-1:0] win_id,
  input logic         win_valid,
  input logic         preempt
);
  logic [N-1:0] req_q;
  logic [2:0]   grp_q;
  logic         act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      grp_q <= 3'd0;
      act_q <= 1'b0;
    end else begin
      req_q <= req_vec;
      grp_q <= grouping;
      act_q <= act_valid;
    end
  end

  // R1
  no_req_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == '0) |-> (!win_valid && !preempt));
  // R1
  winner_is_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> req_q[win_id]);
  // R7
  idle_preempts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && (req_q != '0)) |-> preempt);
  // R8
  all_sub_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && grp_q == 3'd7) |-> !preempt);
  // R6
  preempt_needs_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> win_valid);
endmodule

bind grp_irq_arb grp_irq_arb_chk #(.N(NUM_SRC), .IW(ID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_vec  (req_vec),
  .grouping (grouping),
  .act_valid(act_valid),
  .win_id   (win_id),
  .win_valid(win_valid),
  .preempt  (preempt)
);

// File: tb/grp_irq_arb_tb.sv
`timescale 1ns/1ps
module grp_irq_arb_tb;
  localparam int N  = 43;
  localparam int PW = 4;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pend = '0;
  logic [N-1:0] en = '0;
  logic [N*PW-1:0] prio_flat = '0;
  logic [2:0] grouping = 3'd3;
  logic act_valid = 1'b0;
  logic [PW-1:0] act_prio = '0;
  logic [IW-1:0] win_id;
  logic win_valid, preempt;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  grp_irq_arb u_dut (
    .clk(clk), .rst_n(rst_n), .pend(pend), .en(en), .prio_flat(prio_flat),
    .grouping(grouping), .act_valid(act_valid), .act_prio(act_prio),
    .win_id(win_id), .win_valid(win_valid), .preempt(preempt)
  );

  typedef struct packed {
    logic [5:0] a_id;  logic [3:0] a_p;
    logic [5:0] b_id;  logic [3:0] b_p;
    logic [2:0] g;     logic act;  logic [3:0] ap;
    logic [5:0] e_id;  logic e_pre;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{6'd5,  4'd3,  6'd9,  4'd7,  3'd3, 1'b0, 4'd0,  6'd5,  1'b1}, // R2 R7
    '{6'd5,  4'd7,  6'd9,  4'd3,  3'd3, 1'b1, 4'd4,  6'd9,  1'b1}, // R2 R6
    '{6'd10, 4'd6,  6'd20, 4'd6,  3'd3, 1'b1, 4'd6,  6'd10, 1'b0}, // R3 R6
    '{6'd42, 4'd0,  6'd0,  4'd1,  3'd7, 1'b1, 4'd15, 6'd42, 1'b0}, // R8
    '{6'd1,  4'd5,  6'd2,  4'd4,  3'd4, 1'b1, 4'd5,  6'd2,  1'b0}, // R4 3.1
    '{6'd1,  4'd5,  6'd2,  4'd4,  3'd4, 1'b1, 4'd6,  6'd2,  1'b1}, // R4 3.1
    '{6'd3,  4'd9,  6'd4,  4'd11, 3'd5, 1'b1, 4'd10, 6'd3,  1'b0}, // R4 2.2
    '{6'd3,  4'd9,  6'd4,  4'd11, 3'd0, 1'b1, 4'd10, 6'd3,  1'b1}, // R5
    '{6'd7,  4'd7,  6'd8,  4'd8,  3'd6, 1'b1, 4'd8,  6'd7,  1'b1}  // R4 1.3
  };

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic clear_all();
    pend = '0; en = '0; prio_flat = '0;
  endtask

  task automatic set_src(input int i, input logic [3:0] p);
    pend[i] = 1'b1; en[i] = 1'b1; prio_flat[i*PW +: PW] = p;
  endtask

  // drive at negedge, result is registered at next posedge, sample 1 ns later
  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state, R9
    pend = '1; en = '1;
    repeat (3) @(posedge clk); #1;
    chk("R9 reset valid", win_valid, 0);
    chk("R9 reset preempt", preempt, 0);
    chk("R9 reset id", win_id, 0);
    @(negedge clk); rst_n = 1'b1; clear_all();
    step();

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      clear_all();
      set_src(VECS[v].a_id, VECS[v].a_p);
      set_src(VECS[v].b_id, VECS[v].b_p);
      grouping = VECS[v].g; act_valid = VECS[v].act; act_prio = VECS[v].ap;
      step();
      chk("R2 table id", win_id, VECS[v].e_id);
      chk("R1 table valid", win_valid, 1);
      chk("R6 table preempt", preempt, VECS[v].e_pre);
    end

    // R1: nothing pending
    @(negedge clk); clear_all(); act_valid = 1'b0; step();
    chk("R1 none valid", win_valid, 0);
    chk("R1 none preempt", preempt, 0);

    // R1: pending but disabled sources ignored
    @(negedge clk); clear_all(); grouping = 3'd3;
    set_src(30, 4'd9);
    pend[4] = 1'b1; prio_flat[4*PW +: PW] = 4'd0;
    en[6] = 1'b1; prio_flat[6*PW +: PW] = 4'd0;
    step();
    chk("R1 disabled id", win_id, 30);
    chk("R1 disabled valid", win_valid, 1);

    // R3: every source at one level
    @(negedge clk); clear_all();
    for (int i = 0; i < N; i++) set_src(i, 4'd12);
    act_valid = 1'b1; act_prio = 4'd12;
    step();
    chk("R3 all equal id", win_id, 0);
    chk("R6 equal group preempt", preempt, 0);

    // R2: highest index with best priority
    @(negedge clk); prio_flat[42*PW +: PW] = 4'd2; step();
    chk("R2 top index id", win_id, 42);
    chk("R6 lower group preempt", preempt, 1);

    // R8: split 0.4, active lowest urgency, winner most urgent
    @(negedge clk); grouping = 3'd7; act_prio = 4'd15; prio_flat[42*PW +: PW] = 4'd0;
    step();
    chk("R8 no preempt", preempt, 0);
    // R7: same with idle handler
    @(negedge clk); act_valid = 1'b0; step();
    chk("R7 idle preempt", preempt, 1);

    // R9: one-cycle latency, a single-cycle change
    @(negedge clk); clear_all(); set_src(17, 4'd1); grouping = 3'd3;
    @(posedge clk); #1;
    @(negedge clk); clear_all(); set_src(25, 4'd1);
    chk("R9 latency first", win_id, 17);
    @(posedge clk); #1;
    chk("R9 latency second", win_id, 25);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule